// File: doc/BRIEF.md
# Fast Reference No-Activity Monitor

This block watches the reference clock that a digital PLL currently tracks. It works in a fast system clock. Each reference edge arrives as a one-cycle strobe, and the block counts system clocks between strobes. When edges stop for about two expected periods, or about four on a high-rate reference, it raises a mini-holdover request. The PLL can then stop following the reference at once. A single period that falls outside a coarse window around the expected period is handled the same way.

Each such event also does three things:
- It sets a latched failure status, which can drive an interrupt and an optional dedicated pin.
- Depending on a control input, it either leaves lock untouched, so tracking later resumes with nearest-edge locking, or declares loss of lock. Loss of lock selects phase/frequency re-acquisition, which lasts until the loop reports lock again.
- A parameter selects a secondary-PLL variant that never sets the failure status.

Top module: `ref_activity_mon`

## Requirements
- R1: After reset, holdover, fail_sts, lock_sts, lol, irq and fail_pin are all 0.
- R2: The elapsed count E works as follows:
  - E is 0 after reset.
  - E is 1 in the cycle after a ref_edge strobe.
  - Otherwise E rises by one per cycle and saturates at its maximum.
  - With high_rate=0, a cycle without ref_edge in which E >= 2*exp_period+MARGIN is a timeout. A timeout raises holdover in the next cycle.
- R3: With high_rate=1, the timeout threshold is 4*exp_period+MARGIN.
- R4: A ref_edge outside holdover, after at least one earlier edge since reset, is checked against a window. It is an event when E lies outside exp_period ± (exp_period >> TOL_SHIFT). An event raises holdover in the next cycle. An edge inside the window causes nothing.
- R5: In holdover, the next ref_edge clears holdover in the following cycle. No new event is taken while holdover is 1.
- R6: In the primary variant (SECONDARY=0), an event sets fail_sts. A clr_fail pulse clears it, and set wins over clear in the same cycle.
- R7: fail_pin equals fail_sts when pin_en=1 and is 0 otherwise.
- R8: With nalol=0, an event leaves lol and lock_sts unchanged. Tracking then resumes in nearest-edge mode.
- R9: With nalol=1, an event sets lol (phase/frequency re-acquisition selected) and sets lock_sts. lol clears in the cycle after one in which holdover=0 and pll_locked=1.
- R10: irq is (fail_sts AND fail_ie) OR (lock_sts AND lock_ie).
- R11: With SECONDARY=1, fail_sts never becomes 1. Holdover, lol and lock_sts behave as in R2 to R9.
- R12: A clr_lock pulse clears lock_sts, and set wins over clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe per reference edge |
| exp_period | input | CNT_W | Expected reference period in system clocks |
| high_rate | input | 1 | Selects the four-period timeout |
| nalol | input | 1 | 1: events declare loss of lock |
| pll_locked | input | 1 | Phase lock regained by the loop |
| fail_ie | input | 1 | Interrupt enable for fail_sts |
| lock_ie | input | 1 | Interrupt enable for lock_sts |
| pin_en | input | 1 | Enables fail_pin |
| clr_fail | input | 1 | Write-one-to-clear strobe for fail_sts |
| clr_lock | input | 1 | Write-one-to-clear strobe for lock_sts |
| holdover | output | 1 | Mini-holdover request |
| fail_sts | output | 1 | Latched reference failure |
| lock_sts | output | 1 | Latched lock-state change |
| lol | output | 1 | Loss of lock; 1 selects phase/frequency locking |
| irq | output | 1 | Interrupt request |
| fail_pin | output | 1 | Failure pin output |

## Verification
The bench builds a primary and a secondary instance with CNT_W=8, MARGIN=3 and TOL_SHIFT=3.

Short timeouts make both threshold multipliers reachable in a few dozen cycles. These are 35 and 67 cycles for a period of 16. The wide window of 14 to 18 lets in-range and out-of-range periods differ by a couple of cycles.

The narrow count width means a long dead reference drives the elapsed count into saturation within the run. The two instances show side by side how the failure status differs between the variants.

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
  parameter int CNT_W     = 16,
  parameter int MARGIN    = 4,
  parameter int TOL_SHIFT = 7,
  parameter bit SECONDARY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic [CNT_W-1:0] exp_period,
  input  logic             high_rate,
  input  logic             nalol,
  input  logic             pll_locked,
  input  logic             fail_ie,
  input  logic             lock_ie,
  input  logic             pin_en,
  input  logic             clr_fail,
  input  logic             clr_lock,
  output logic             holdover,
  output logic             fail_sts,
  output logic             lock_sts,
  output logic             lol,
  output logic             irq,
  output logic             fail_pin
);
  localparam int GW = CNT_W + 3;

  logic [GW-1:0] gap, per, tol, limit, lo, hi;
  logic primed, timeout, freq_bad, evt;

  assign per   = GW'(exp_period);
  assign tol   = per >> TOL_SHIFT;
  assign limit = (high_rate ? (per << 2) : (per << 1)) + GW'(MARGIN);
  assign lo    = per - tol;
  assign hi    = per + tol;

  assign timeout  = !ref_edge && (gap >= limit);
  assign freq_bad = ref_edge && primed && ((gap < lo) || (gap > hi));
  assign evt      = !holdover && (timeout || freq_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap      <= '0;
      primed   <= 1'b0;
      holdover <= 1'b0;
      lol      <= 1'b0;
      lock_sts <= 1'b0;
    end else begin
      if (ref_edge)        gap <= GW'(1);
      else if (gap != '1)  gap <= gap + GW'(1);
      if (ref_edge) primed <= 1'b1;

      if (evt)                      holdover <= 1'b1;
      else if (holdover && ref_edge) holdover <= 1'b0;

      if (evt && nalol)                     lol <= 1'b1;
      else if (lol && !holdover && pll_locked) lol <= 1'b0;

      if (evt && nalol)  lock_sts <= 1'b1;
      else if (clr_lock) lock_sts <= 1'b0;
    end
  end

  generate
    if (SECONDARY) begin : g_sec
      assign fail_sts = 1'b0;
    end else begin : g_pri
      logic fail_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        fail_q <= 1'b0;
        else if (evt)      fail_q <= 1'b1;
        else if (clr_fail) fail_q <= 1'b0;
      end
      assign fail_sts = fail_q;
    end
  endgenerate

  assign irq      = (fail_sts && fail_ie) || (lock_sts && lock_ie);
  assign fail_pin = pin_en && fail_sts;
endmodule

// File: rtl/ref_activity_mon_chk.sv
module ref_activity_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_edge,
  input logic nalol,
  input logic holdover,
  input logic fail_sts,
  input logic lock_sts,
  input logic lol,
  input logic irq,
  input logic fail_pin
);
  AST_FAIL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_sts) |-> holdover); // R6
  AST_EXIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover) |-> $past(ref_edge)); // R5
  AST_LOL_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lol) |-> $past(nalol)); // R8
  AST_LOL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lol) |-> lock_sts && holdover); // R9
  AST_PIN_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pin |-> fail_sts); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (fail_sts || lock_sts)); // R10
endmodule

bind ref_activity_mon ref_activity_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .nalol(nalol),
  .holdover(holdover), .fail_sts(fail_sts), .lock_sts(lock_sts),
  .lol(lol), .irq(irq), .fail_pin(fail_pin)
);

// File: tb/sim_ref_activity_mon.sv
module sim_ref_activity_mon;
  localparam int CLK_P = 10;
  localparam int CW = 8, MG = 3, TS = 3;
  localparam int EMAX = (1 << (CW + 3)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, ref_edge = 1'b0;
  logic [CW-1:0] exp_period = 8'd16;
  logic high_rate = 1'b0, nalol = 1'b0, pll_locked = 1'b0;
  logic fail_ie = 1'b0, lock_ie = 1'b0, pin_en = 1'b0, clr_fail = 1'b0, clr_lock = 1'b0;
  logic [1:0] ho, fs, ls, ll, iq, fp;

  always #(CLK_P/2) clk = ~clk;

  ref_activity_mon #(.CNT_W(CW), .MARGIN(MG), .TOL_SHIFT(TS), .SECONDARY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .exp_period(exp_period),
    .high_rate(high_rate), .nalol(nalol), .pll_locked(pll_locked), .fail_ie(fail_ie),
    .lock_ie(lock_ie), .pin_en(pin_en), .clr_fail(clr_fail), .clr_lock(clr_lock),
    .holdover(ho[0]), .fail_sts(fs[0]), .lock_sts(ls[0]), .lol(ll[0]), .irq(iq[0]), .fail_pin(fp[0]));

  ref_activity_mon #(.CNT_W(CW), .MARGIN(MG), .TOL_SHIFT(TS), .SECONDARY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .exp_period(exp_period),
    .high_rate(high_rate), .nalol(nalol), .pll_locked(pll_locked), .fail_ie(fail_ie),
    .lock_ie(lock_ie), .pin_en(pin_en), .clr_fail(clr_fail), .clr_lock(clr_lock),
    .holdover(ho[1]), .fail_sts(fs[1]), .lock_sts(ls[1]), .lol(ll[1]), .irq(iq[1]), .fail_pin(fp[1]));

  int vecs = 0, bad = 0;
  bit done = 0;
  int m_e [2], m_pr [2], m_ho [2], m_fs [2], m_ls [2], m_ll [2];

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_e[v] = 0; m_pr[v] = 0; m_ho[v] = 0; m_fs[v] = 0; m_ls[v] = 0; m_ll[v] = 0;
      end else begin
        int p, lim, tl, ev;
        p   = int'(exp_period);
        lim = p * (high_rate ? 4 : 2) + MG;
        tl  = p >> TS;
        ev  = 0;
        if (m_ho[v] == 0) begin
          if (!ref_edge && m_e[v] >= lim) ev = 1;
          if (ref_edge && m_pr[v] == 1 && (m_e[v] < p - tl || m_e[v] > p + tl)) ev = 1;
        end
        if (ev == 1) begin
          m_ho[v] = 1;
          if (v == 0) m_fs[v] = 1;
          if (nalol) begin m_ll[v] = 1; m_ls[v] = 1; end
        end else begin
          if (m_ho[v] == 1 && ref_edge) m_ho[v] = 0;
          else if (m_ll[v] == 1 && m_ho[v] == 0 && pll_locked) m_ll[v] = 0;
          if (clr_fail) m_fs[v] = 0;
          if (clr_lock) m_ls[v] = 0;
        end
        if (ref_edge) m_pr[v] = 1;
        m_e[v] = ref_edge ? 1 : (m_e[v] + 1 > EMAX ? EMAX : m_e[v] + 1);
      end
    end
  end

  task automatic chk(input logic act, input int expv, input string tag, input int v);
    vecs++;
    if (act !== expv[0]) begin
      bad++;
      $display("FAIL %s inst%0d at %0t: actual %b expected %0d", tag, v, $time, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        for (int v = 0; v < 2; v++) begin
          chk(ho[v], m_ho[v], "R2/R3/R4/R5 holdover", v);
          chk(fs[v], m_fs[v], "R6/R11 fail_sts", v);
          chk(ls[v], m_ls[v], "R9/R12 lock_sts", v);
          chk(ll[v], m_ll[v], "R8/R9 lol", v);
          chk(iq[v], (m_fs[v] & int'(fail_ie)) | (m_ls[v] & int'(lock_ie)), "R10 irq", v);
          chk(fp[v], m_fs[v] & int'(pin_en), "R7 fail_pin", v);
        end
      end
    end
  end

  task automatic edges(input int period, input int n);
    for (int i = 0; i < n; i++) begin
      repeat (period - 1) @(negedge clk);
      ref_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit f, input bit l);
    clr_fail = f; clr_lock = l;
    @(negedge clk);
    clr_fail = 1'b0; clr_lock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    for (int v = 0; v < 2; v++)
      chk(ho[v] | fs[v] | ls[v] | ll[v] | iq[v] | fp[v], 0, "R1 reset state", v);
    fail_ie = 1'b1; pin_en = 1'b1;
    edges(16, 8);
    idle(50);
    edges(16, 6);
    pulse_clr(1, 0);
    edges(16, 4);
    high_rate = 1'b1;
    idle(50);
    edges(16, 4);
    idle(80);
    edges(16, 4);
    high_rate = 1'b0;
    edges(20, 1);
    edges(16, 3);
    edges(17, 4);
    edges(14, 3);
    edges(19, 2);
    edges(16, 4);
    pin_en = 1'b0;
    pulse_clr(1, 0);
    nalol = 1'b1; lock_ie = 1'b1;
    edges(16, 3);
    idle(45);
    edges(16, 4);
    pll_locked = 1'b1;
    edges(16, 2);
    pll_locked = 1'b0;
    pulse_clr(0, 1);
    edges(16, 2);
    fail_ie = 1'b0;
    idle(2200);
    edges(16, 3);
    pll_locked = 1'b1;
    clr_fail = 1'b1; clr_lock = 1'b1;
    idle(3);
    clr_fail = 1'b0; clr_lock = 1'b0;
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule